// File: doc/BRIEF.md
# Shift, Rotate and Status-Bit Unit

This block handles the single-operand bit-movement work of an 8-bit processor datapath. It takes one register value, an operation code, a bit index and the current status register. It returns the transformed register value and the new status register. It covers logical and arithmetic shifts, rotates through carry, and exchanging the two nibbles of the byte. It also covers setting or clearing one status bit, and moving one register bit to or from the T flag.

All inputs are sampled on a rising clock edge. Both results appear on the outputs one cycle later, held in registers. The surrounding pipeline writes `result_o` back to the register file and `sreg_o` back to the status register. The status register bit order is C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.

Top module: `fsu_shift_flag_unit`

## Requirements
- R1: While `rst_ni` is low, `result_o` and `sreg_o` are 0. Otherwise the outputs reflect the inputs sampled at the previous rising edge.
- R2: Op code 0 (shift left) gives result = operand shifted up one bit with 0 in bit 0, and C = old bit 7.
- R3: Op code 1 (logical shift right) gives result = operand shifted down one bit with 0 in bit 7, and C = old bit 0.
- R4: Op code 2 (rotate left through carry) puts the incoming C in bit 0, shifts the other bits up, and sets C = old bit 7.
- R5: Op code 3 (rotate right through carry) puts the incoming C in bit 7, shifts the other bits down, and sets C = old bit 0.
- R6: Op code 4 (arithmetic shift right) shifts bits 7..1 into 6..0, keeps bit 7, and sets C = old bit 0.
- R7: For op codes 0 to 4, the flags are set as follows:
  - Z = (result == 0).
  - N = result bit 7.
  - V = N xor C.
  - S = N xor V.
  - H, T and I are passed through unchanged.
- R8: Op code 5 (nibble swap) exchanges bits 3..0 with bits 7..4 and returns the status register unchanged.
- R9: Op codes 6 and 7 set or clear status bit `bit_idx_i[2:0]`, respectively. The other status bits are unchanged and the result equals the operand.
- R10: Op code 8 (bit store) copies operand bit `bit_idx_i` into T (status bit 6). The other status bits are unchanged and the result equals the operand.
- R11: Op code 9 (bit load) writes T into result bit `bit_idx_i`. The other result bits come from the operand and the status register is unchanged.
- R12: Op codes 10 to 15 have no effect: the result equals the operand and the status register is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| operand_i | input | 8 | Register value to transform |
| bit_idx_i | input | 3 | Bit index for register or status-bit operations |
| sreg_i | input | 8 | Current status register |
| result_o | output | 8 | Registered result value |
| sreg_o | output | 8 | Registered new status register |

## Verification
Every operation, whether it is a shift, a swap or a status-bit operation, produces its result and status register exactly one rising edge after the inputs are presented. Nothing depends on earlier operations.

The bench drives a new operation on each falling edge. It compares both outputs on the following falling edge, just after the single register stage has captured the operation. The expected values come from a bench model of the requirements.

Stimulus is mostly random over all sixteen op codes, all indices and all status values. It adds directed cases for these boundaries:
- Shifts that produce zero.
- A carry rotating into the top or bottom bit.
- Sign retention on an arithmetic shift.
- Bit operations at index 0 and index 7.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int unsigned SREG_W   = 8;
  localparam int unsigned SR_IDX_W = 3;
  localparam int unsigned OP_W     = 4;

  localparam int unsigned SR_C = 0;
  localparam int unsigned SR_Z = 1;
  localparam int unsigned SR_N = 2;
  localparam int unsigned SR_V = 3;
  localparam int unsigned SR_S = 4;
  localparam int unsigned SR_H = 5;
  localparam int unsigned SR_T = 6;
  localparam int unsigned SR_I = 7;

  localparam logic [OP_W-1:0] OP_SHL    = 4'd0;
  localparam logic [OP_W-1:0] OP_SHR    = 4'd1;
  localparam logic [OP_W-1:0] OP_RCL    = 4'd2;
  localparam logic [OP_W-1:0] OP_RCR    = 4'd3;
  localparam logic [OP_W-1:0] OP_SAR    = 4'd4;
  localparam logic [OP_W-1:0] OP_NSWAP  = 4'd5;
  localparam logic [OP_W-1:0] OP_FSET   = 4'd6;
  localparam logic [OP_W-1:0] OP_FCLR   = 4'd7;
  localparam logic [OP_W-1:0] OP_TSTORE = 4'd8;
  localparam logic [OP_W-1:0] OP_TLOAD  = 4'd9;

  typedef enum logic [1:0] {
    SEL_PASS  = 2'd0,
    SEL_SHIFT = 2'd1,
    SEL_SWAP  = 2'd2,
    SEL_BIT   = 2'd3
  } fsu_sel_e;
endpackage

// File: rtl/fsu_shifter.sv
module fsu_shifter
  import fsu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    operand_i,
  input  logic            carry_i,
  output logic [W-1:0]    result_o,
  output logic            carry_o
);
  localparam int unsigned HALF = W / 2;

  always_comb begin
    result_o = operand_i;
    carry_o  = carry_i;
    unique case (op_i)
      OP_SHL: begin
        result_o = {operand_i[W-2:0], 1'b0};
        carry_o  = operand_i[W-1];
      end
      OP_SHR: begin
        result_o = {1'b0, operand_i[W-1:1]};
        carry_o  = operand_i[0];
      end
      OP_RCL: begin
        result_o = {operand_i[W-2:0], carry_i};
        carry_o  = operand_i[W-1];
      end
      OP_RCR: begin
        result_o = {carry_i, operand_i[W-1:1]};
        carry_o  = operand_i[0];
      end
      OP_SAR: begin
        result_o = {operand_i[W-1], operand_i[W-1:1]};
        carry_o  = operand_i[0];
      end
      OP_NSWAP: result_o = {operand_i[HALF-1:0], operand_i[W-1:HALF]};
      default: ;
    endcase
  end
endmodule

// File: rtl/fsu_flag_gen.sv
module fsu_flag_gen
  import fsu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]      result_i,
  input  logic              carry_i,
  input  logic [SREG_W-1:0] sreg_i,
  output logic [SREG_W-1:0] sreg_o
);
  logic neg, ovf;

  always_comb begin
    neg          = result_i[W-1];
    ovf          = neg ^ carry_i;
    sreg_o       = sreg_i;
    sreg_o[SR_C] = carry_i;
    sreg_o[SR_Z] = (result_i == '0);
    sreg_o[SR_N] = neg;
    sreg_o[SR_V] = ovf;
    sreg_o[SR_S] = neg ^ ovf;
  end
endmodule

// File: rtl/fsu_bitops.sv
module fsu_bitops
  import fsu_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [W-1:0]      operand_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [SREG_W-1:0] sreg_i,
  output logic [W-1:0]      result_o,
  output logic [SREG_W-1:0] sreg_o
);
  logic [SR_IDX_W-1:0] sidx;
  assign sidx = idx_i[SR_IDX_W-1:0];

  always_comb begin
    result_o = operand_i;
    sreg_o   = sreg_i;
    unique case (op_i)
      OP_FSET:   sreg_o[sidx]  = 1'b1;
      OP_FCLR:   sreg_o[sidx]  = 1'b0;
      OP_TSTORE: sreg_o[SR_T]  = operand_i[idx_i];
      OP_TLOAD:  result_o[idx_i] = sreg_i[SR_T];
      default: ;
    endcase
  end
endmodule

// File: rtl/fsu_shift_flag_unit.sv
module fsu_shift_flag_unit
  import fsu_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [W-1:0]      operand_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic [SREG_W-1:0] sreg_i,
  output logic [W-1:0]      result_o,
  output logic [SREG_W-1:0] sreg_o
);
  logic [W-1:0]      sh_res, bo_res, res_d;
  logic              sh_carry;
  logic [SREG_W-1:0] fl_sreg, bo_sreg, sreg_d;
  fsu_sel_e          sel;

  fsu_shifter #(.W(W)) u_shifter (
    .op_i      (op_i),
    .operand_i (operand_i),
    .carry_i   (sreg_i[SR_C]),
    .result_o  (sh_res),
    .carry_o   (sh_carry)
  );

  fsu_flag_gen #(.W(W)) u_flag_gen (
    .result_i (sh_res),
    .carry_i  (sh_carry),
    .sreg_i   (sreg_i),
    .sreg_o   (fl_sreg)
  );

  fsu_bitops #(.W(W), .IDX_W(IDX_W)) u_bitops (
    .op_i      (op_i),
    .operand_i (operand_i),
    .idx_i     (bit_idx_i),
    .sreg_i    (sreg_i),
    .result_o  (bo_res),
    .sreg_o    (bo_sreg)
  );

  always_comb begin
    unique case (op_i)
      OP_SHL, OP_SHR, OP_RCL, OP_RCR, OP_SAR: sel = SEL_SHIFT;
      OP_NSWAP:                               sel = SEL_SWAP;
      OP_FSET, OP_FCLR, OP_TSTORE, OP_TLOAD:  sel = SEL_BIT;
      default:                                sel = SEL_PASS;
    endcase
  end

  always_comb begin
    unique case (sel)
      SEL_SHIFT: begin res_d = sh_res;    sreg_d = fl_sreg; end
      SEL_SWAP:  begin res_d = sh_res;    sreg_d = sreg_i;  end
      SEL_BIT:   begin res_d = bo_res;    sreg_d = bo_sreg; end
      default:   begin res_d = operand_i; sreg_d = sreg_i;  end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      sreg_o   <= '0;
    end else begin
      result_o <= res_d;
      sreg_o   <= sreg_d;
    end
  end
endmodule

// File: rtl/fsu_shift_flag_unit_chk.sv
module fsu_shift_flag_unit_chk
  import fsu_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OP_W-1:0]   op_i,
  input logic [W-1:0]      operand_i,
  input logic [IDX_W-1:0]  bit_idx_i,
  input logic [SREG_W-1:0] sreg_i,
  input logic [W-1:0]      result_o,
  input logic [SREG_W-1:0] sreg_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) a_r1_reset_zero: assert (result_o == '0 && sreg_o == '0);
  end

  a_r2_shl_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(op_i) == OP_SHL |->
      result_o == {$past(operand_i[W-2:0]), 1'b0} && sreg_o[SR_C] == $past(operand_i[W-1]));

  a_r4_rcl_carry_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(op_i) == OP_RCL |-> result_o[0] == $past(sreg_i[SR_C]));

  a_r6_sar_sign_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(op_i) == OP_SAR |-> result_o[W-1] == $past(operand_i[W-1]));

  a_r7_flag_rules: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(op_i) <= OP_SAR |->
      sreg_o[SR_Z] == (result_o == '0) && sreg_o[SR_N] == result_o[W-1] &&
      sreg_o[SR_V] == (sreg_o[SR_N] ^ sreg_o[SR_C]) &&
      sreg_o[SR_S] == (sreg_o[SR_N] ^ sreg_o[SR_V]) &&
      sreg_o[SR_I:SR_H] == $past(sreg_i[SR_I:SR_H]));

  a_r8_swap_flags_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(op_i) == OP_NSWAP |-> sreg_o == $past(sreg_i));

  a_r10_tstore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(op_i) == OP_TSTORE |->
      result_o == $past(operand_i) && sreg_o[SR_T] == $past(operand_i[bit_idx_i]));

  a_r11_tload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(op_i) == OP_TLOAD |->
      sreg_o == $past(sreg_i) && result_o[$past(bit_idx_i)] == $past(sreg_i[SR_T]));

  a_r12_idle_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(op_i) > OP_TLOAD |->
      result_o == $past(operand_i) && sreg_o == $past(sreg_i));
endmodule

bind fsu_shift_flag_unit fsu_shift_flag_unit_chk #(.W(W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/fsu_shift_flag_unit_test.sv
module fsu_shift_flag_unit_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] operand_i = '0;
  logic [2:0] bit_idx_i = '0;
  logic [7:0] sreg_i = '0;
  logic [7:0] result_o, sreg_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  fsu_shift_flag_unit uut (.*);

  function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [2:0] ix, input logic [7:0] sr);
    logic [7:0] r = a;
    logic [7:0] s = sr;
    logic c = sr[0];
    logic n, v;
    case (op)
      4'd0: begin r = a << 1;              c = a[7]; end
      4'd1: begin r = a >> 1;              c = a[0]; end
      4'd2: begin r = {a[6:0], sr[0]};     c = a[7]; end
      4'd3: begin r = {sr[0], a[7:1]};     c = a[0]; end
      4'd4: begin r = {a[7], a[7:1]};      c = a[0]; end
      4'd5: r = {a[3:0], a[7:4]};
      4'd6: s[ix] = 1'b1;
      4'd7: s[ix] = 1'b0;
      4'd8: s[6] = a[ix];
      4'd9: r[ix] = sr[6];
      default: ;
    endcase
    if (op <= 4'd4) begin
      n = r[7];
      v = n ^ c;
      s[0] = c; s[1] = (r == 8'h00); s[2] = n; s[3] = v; s[4] = n ^ v;
    end
    return {r, s};
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R2/R7";
      4'd1: return "R3/R7";
      4'd2: return "R4/R7";
      4'd3: return "R5/R7";
      4'd4: return "R6/R7";
      4'd5: return "R8";
      4'd6, 4'd7: return "R9";
      4'd8: return "R10";
      4'd9: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got res=%h sreg=%h expected res=%h sreg=%h",
               req, got[15:8], got[7:0], exp[15:8], exp[7:0]);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [7:0] a,
                     input logic [2:0] ix, input logic [7:0] sr);
    logic [15:0] exp;
    @(negedge clk_i);
    op_i = op; operand_i = a; bit_idx_i = ix; sreg_i = sr;
    exp = model(op, a, ix, sr);
    @(negedge clk_i);
    check(req_of(op), {result_o, sreg_o}, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    op_i = 4'd0; operand_i = 8'hff; sreg_i = 8'hff;
    repeat (3) @(negedge clk_i);
    check("R1", {result_o, sreg_o}, 16'h0000);  // R1: reset state
    rst_ni = 1'b1;

    run(4'd0, 8'h80, 3'd0, 8'h00);  // R2: shift to zero, C=1 Z=1 V=1 S=1
    run(4'd1, 8'h01, 3'd0, 8'he0);  // R3: zero result, H/T/I kept
    run(4'd2, 8'h80, 3'd0, 8'h01);  // R4: carry into bit 0
    run(4'd3, 8'h01, 3'd0, 8'h01);  // R5: carry into bit 7
    run(4'd4, 8'h81, 3'd0, 8'h00);  // R6: sign kept
    run(4'd4, 8'h7e, 3'd0, 8'hff);  // R6/R7
    run(4'd5, 8'h3c, 3'd0, 8'h5a);  // R8
    run(4'd6, 8'h11, 3'd7, 8'h00);  // R9: set I
    run(4'd7, 8'h11, 3'd0, 8'hff);  // R9: clear C
    run(4'd8, 8'h80, 3'd7, 8'h00);  // R10
    run(4'd8, 8'hfe, 3'd0, 8'hff);  // R10: T cleared
    run(4'd9, 8'h00, 3'd7, 8'h40);  // R11
    run(4'd9, 8'hff, 3'd0, 8'h00);  // R11
    run(4'd15, 8'ha5, 3'd3, 8'h3c); // R12

    for (int i = 0; i < 3000; i++)
      run(4'($urandom), 8'($urandom), 3'($urandom), 8'($urandom));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule